// File: doc/BRIEF.md
# Masked Multi-Pin Output Compare Unit

This block is one output-compare channel of a timer, built to move a group of port pins together. Each clock it looks at a 16-bit free-running count supplied from outside. On a cycle where the count advances and equals the programmed compare value, the channel performs its pin action. Every pin selected by the select register takes the level held in the matching bit of the level register. Pins that are not selected keep whatever they were driving. The same cycle also raises an interrupt flag.

Software can trigger the pin action without waiting for the count. It writes a one to the channel-1 bit of the strobe register. That bit belongs to a five-bit group of one-shot strobes, one per timer channel, and each strobe is also sent out as a single-cycle pulse for the other channels to use. A forced action moves the pins but leaves the flag alone.

Registers sit on a simple byte-wide bus with a combinational read path. The flag is cleared by writing a one to it. Reset is applied asynchronously and released synchronously inside the block, two clock edges after `rst_n` rises.

Top module: `ocm_unit`

## Requirements
- R1: After reset, `pins_o`, `irq_o` and `force_o` are zero, and every register address (0 compare high byte, 1 compare low byte, 2 select, 3 level, 4 strobe, 5 flag) reads 0x00.
- R2: The select register (address 2) and the level register (address 3) hold only bits 7..3, and bits 2..0 read as zero. The strobe register (address 4) always reads 0x00.
- R3: When `cnt_adv_i` is high and `cnt_i` equals the compare value, then at the next clock edge each pin whose select bit is set takes the level bit. Register bit 3+i maps to `pins_o[i]`.
- R4: During a pin action, a pin whose select bit is clear keeps its value.
- R5: When `cnt_i` equals the compare value while `cnt_adv_i` is low, the pins do not change and the flag is not set.
- R6: Writing a 1 to bit 7 of the strobe register performs the pin action at the next edge, without setting the flag.
- R7: A strobe-register write drives `force_o[c]` high for exactly the following cycle when written bit 7-c is 1, for channels c = 0..4 (channel 1 is index 0). Zero bits, and cycles without a strobe write, leave `force_o` at zero.
- R8: A counter match sets the flag (`irq_o`, read as bit 7 of address 5) at the next edge. Writing 1 to bit 7 of address 5 clears it, and writing 0 has no effect. A match in the same cycle as a clear leaves the flag set.
- R9: With no match and no channel-1 strobe, `pins_o` holds its value.
- R10: A pin action uses the select, level and compare values held before a register write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 16 | Free-running counter value |
| cnt_adv_i | input | 1 | High on cycles where the counter advances |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| pins_o | output | 5 | Port pins 7..3 as bits 4..0 |
| force_o | output | 5 | One-cycle force pulses, channels 1..5 as bits 0..4 |
| irq_o | output | 1 | Channel-1 compare flag |

## Verification
The collision of interest is a counter match in the same cycle as a bus write to the block's own registers. The write can be a flag clear, a channel-1 strobe, or a new select, level or compare value. Directed cycles provoke each pairing on purpose: a clear that loses to a set, a forced action that coincides with a match, and a level change that must not affect the action already under way. A random phase then steers the counter onto the compare value about half the time while bus writes land on random addresses. A bench model is updated from the pre-write register values, and it judges pins, flag and pulses after every edge.

// File: rtl/ocm_pkg.sv
package ocm_pkg;
  localparam int unsigned A_CMP_HI = 0;
  localparam int unsigned A_CMP_LO = 1;
  localparam int unsigned A_SEL    = 2;
  localparam int unsigned A_LVL    = 3;
  localparam int unsigned A_STROBE = 4;
  localparam int unsigned A_FLAG   = 5;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_MATCH = 2'd1,
    EV_FORCE = 2'd2,
    EV_BOTH  = 2'd3
  } ocm_ev_e;
endpackage

// File: rtl/ocm_rst_sync.sv
module ocm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/ocm_match.sv
module ocm_match #(
  parameter int CNT_W = 16
) (
  input  logic             cnt_adv_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             force1_i,
  output logic             hit_o,
  output ocm_pkg::ocm_ev_e ev_o
);
  logic eq;

  always_comb begin
    eq    = (cnt_i == cmp_i);
    hit_o = cnt_adv_i & eq;
    unique case ({force1_i, hit_o})
      2'b01:   ev_o = ocm_pkg::EV_MATCH;
      2'b10:   ev_o = ocm_pkg::EV_FORCE;
      2'b11:   ev_o = ocm_pkg::EV_BOTH;
      default: ev_o = ocm_pkg::EV_NONE;
    endcase
  end
endmodule

// File: rtl/ocm_regs.sv
module ocm_regs #(
  parameter int AW      = 3,
  parameter int DW      = 8,
  parameter int CNT_W   = 16,
  parameter int PIN_N   = 5,
  parameter int PIN_LSB = 3,
  parameter int CH_N    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic [PIN_N-1:0] sel_o,
  output logic [PIN_N-1:0] lvl_o,
  output logic             force1_now_o,
  output logic [CH_N-1:0]  force_o,
  output logic             flag_o,
  output logic [DW-1:0]    rdata_o
);
  import ocm_pkg::*;

  localparam int HI_W = CNT_W - DW;

  logic             wr_hi, wr_lo, wr_sel, wr_lvl, wr_stb, wr_flag;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic [PIN_N-1:0] sel_q, sel_d, lvl_q, lvl_d;
  logic [CH_N-1:0]  frc_q, frc_d;
  logic             flag_q, flag_d;

  always_comb begin
    wr_hi   = wr_en_i && (addr_i == AW'(A_CMP_HI));
    wr_lo   = wr_en_i && (addr_i == AW'(A_CMP_LO));
    wr_sel  = wr_en_i && (addr_i == AW'(A_SEL));
    wr_lvl  = wr_en_i && (addr_i == AW'(A_LVL));
    wr_stb  = wr_en_i && (addr_i == AW'(A_STROBE));
    wr_flag = wr_en_i && (addr_i == AW'(A_FLAG));
  end

  // next-state
  always_comb begin
    cmp_d = cmp_q;
    if (wr_hi) cmp_d[CNT_W-1:DW] = wdata_i[HI_W-1:0];
    if (wr_lo) cmp_d[DW-1:0]     = wdata_i;
    sel_d  = wr_sel ? wdata_i[PIN_LSB +: PIN_N] : sel_q;
    lvl_d  = wr_lvl ? wdata_i[PIN_LSB +: PIN_N] : lvl_q;
    // set has priority over a write-one clear
    flag_d = hit_i | (flag_q & ~(wr_flag & wdata_i[DW-1]));
  end

  genvar c;
  generate
    for (c = 0; c < CH_N; c++) begin : g_frc
      always_comb frc_d[c] = wr_stb & wdata_i[DW-1-c];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      sel_q  <= '0;
      lvl_q  <= '0;
      frc_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cmp_q  <= cmp_d;
      sel_q  <= sel_d;
      lvl_q  <= lvl_d;
      frc_q  <= frc_d;
      flag_q <= flag_d;
    end
  end

  // read path, unimplemented bits return zero
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AW'(A_CMP_HI): rdata_o[HI_W-1:0]        = cmp_q[CNT_W-1:DW];
      AW'(A_CMP_LO): rdata_o                  = cmp_q[DW-1:0];
      AW'(A_SEL):    rdata_o[PIN_LSB +: PIN_N] = sel_q;
      AW'(A_LVL):    rdata_o[PIN_LSB +: PIN_N] = lvl_q;
      AW'(A_FLAG):   rdata_o[DW-1]            = flag_q;
      default:       rdata_o                  = '0;
    endcase
  end

  assign cmp_o        = cmp_q;
  assign sel_o        = sel_q;
  assign lvl_o        = lvl_q;
  assign force1_now_o = frc_d[0];
  assign force_o      = frc_q;
  assign flag_o       = flag_q;
endmodule

// File: rtl/ocm_pins.sv
module ocm_pins #(
  parameter int PIN_N = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ocm_pkg::ocm_ev_e ev_i,
  input  logic [PIN_N-1:0] sel_i,
  input  logic [PIN_N-1:0] lvl_i,
  output logic [PIN_N-1:0] pins_o
);
  logic             act;
  logic [PIN_N-1:0] pin_q, pin_d, pin_en;

  always_comb act = (ev_i != ocm_pkg::EV_NONE);

  genvar i;
  generate
    for (i = 0; i < PIN_N; i++) begin : g_pin
      always_comb begin
        pin_en[i] = act & sel_i[i];
        pin_d[i]  = pin_en[i] ? lvl_i[i] : pin_q[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_d;
  end

  assign pins_o = pin_q;
endmodule

// File: rtl/ocm_unit.sv
module ocm_unit #(
  parameter int AW      = 3,
  parameter int DW      = 8,
  parameter int CNT_W   = 16,
  parameter int PIN_N   = 5,
  parameter int PIN_LSB = 3,
  parameter int CH_N    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_adv_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [PIN_N-1:0] pins_o,
  output logic [CH_N-1:0]  force_o,
  output logic             irq_o
);
  logic             rst_n_s;
  logic             hit;
  logic             force1_now;
  logic [CNT_W-1:0] cmp_q;
  logic [PIN_N-1:0] sel_q, lvl_q;
  ocm_pkg::ocm_ev_e ev;

  ocm_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  ocm_regs #(
    .AW(AW), .DW(DW), .CNT_W(CNT_W),
    .PIN_N(PIN_N), .PIN_LSB(PIN_LSB), .CH_N(CH_N)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .wr_en_i      (wr_en_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .hit_i        (hit),
    .cmp_o        (cmp_q),
    .sel_o        (sel_q),
    .lvl_o        (lvl_q),
    .force1_now_o (force1_now),
    .force_o      (force_o),
    .flag_o       (irq_o),
    .rdata_o      (rdata_o)
  );

  ocm_match #(.CNT_W(CNT_W)) u_match (
    .cnt_adv_i (cnt_adv_i),
    .cnt_i     (cnt_i),
    .cmp_i     (cmp_q),
    .force1_i  (force1_now),
    .hit_o     (hit),
    .ev_o      (ev)
  );

  ocm_pins #(.PIN_N(PIN_N)) u_pins (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .ev_i   (ev),
    .sel_i  (sel_q),
    .lvl_i  (lvl_q),
    .pins_o (pins_o)
  );
endmodule

// File: rtl/ocm_unit_chk.sv
module ocm_unit_chk #(
  parameter int AW    = 3,
  parameter int DW    = 8,
  parameter int CNT_W = 16,
  parameter int PIN_N = 5,
  parameter int CH_N  = 5
) (
  input logic             clk,
  input logic             rst_n_s,
  input logic [CNT_W-1:0] cnt_i,
  input logic             cnt_adv_i,
  input logic [CNT_W-1:0] cmp_q,
  input logic             wr_en_i,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic [DW-1:0]    rdata_o,
  input logic [PIN_N-1:0] sel_q,
  input logic [PIN_N-1:0] pins_o,
  input logic [CH_N-1:0]  force_o,
  input logic             irq_o
);
  logic match_c, strobe1_c, stb_wr_c, clr_c;
  always_comb begin
    match_c   = cnt_adv_i && (cnt_i == cmp_q);
    stb_wr_c  = wr_en_i && (addr_i == AW'(ocm_pkg::A_STROBE));
    strobe1_c = stb_wr_c && wdata_i[DW-1];
    clr_c     = wr_en_i && (addr_i == AW'(ocm_pkg::A_FLAG)) && wdata_i[DW-1];
  end

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    match_c |=> irq_o);

  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (irq_o && !clr_c) |=> irq_o);

  p_no_flag_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!irq_o && !match_c) |=> !irq_o);

  p_pulse_idle_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    !stb_wr_c |=> (force_o == '0));

  p_pins_hold_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!match_c && !strobe1_c) |=> $stable(pins_o));

  p_unsel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (match_c || strobe1_c) |=> (((pins_o ^ $past(pins_o)) & ~$past(sel_q)) == '0));

  p_strobe_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (addr_i == AW'(ocm_pkg::A_STROBE)) |-> (rdata_o == '0));
endmodule

bind ocm_unit ocm_unit_chk #(
  .AW(AW), .DW(DW), .CNT_W(CNT_W), .PIN_N(PIN_N), .CH_N(CH_N)
) u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .cnt_i     (cnt_i),
  .cnt_adv_i (cnt_adv_i),
  .cmp_q     (cmp_q),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .sel_q     (sel_q),
  .pins_o    (pins_o),
  .force_o   (force_o),
  .irq_o     (irq_o)
);

// File: tb/tb_ocm_unit.sv
module tb_ocm_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [15:0] cnt_i;
  logic        cnt_adv_i;
  logic        wr_en_i;
  logic [2:0]  addr_i;
  logic [7:0]  wdata_i;
  logic [7:0]  rdata_o;
  logic [4:0]  pins_o;
  logic [4:0]  force_o;
  logic        irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model
  logic [15:0] m_cmp;
  logic [4:0]  m_sel, m_lvl, m_pins, m_frc;
  logic        m_flag;

  ocm_unit dut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cnt_adv_i(cnt_adv_i),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pins_o(pins_o), .force_o(force_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0:    return m_cmp[15:8];
      3'd1:    return m_cmp[7:0];
      3'd2:    return {m_sel, 3'b000};
      3'd3:    return {m_lvl, 3'b000};
      3'd5:    return {m_flag, 7'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, advance model, check at next negedge
  task automatic cyc(input string tag, input logic wr, input logic [2:0] a,
                     input logic [7:0] wd, input logic [15:0] cnt, input logic adv,
                     input bit rd_chk);
    logic        hit, f1, act;
    logic [4:0]  n_pins, n_frc, n_sel, n_lvl;
    logic [15:0] n_cmp;
    logic        n_flag;
    wr_en_i = wr; addr_i = a; wdata_i = wd; cnt_i = cnt; cnt_adv_i = adv;
    #1;
    if (rd_chk) check({tag, " read"}, {8'h00, rdata_o}, {8'h00, exp_read(a)});
    hit    = adv && (cnt == m_cmp);
    f1     = wr && (a == 3'd4) && wd[7];
    act    = hit || f1;
    n_pins = act ? ((m_pins & ~m_sel) | (m_lvl & m_sel)) : m_pins;
    n_flag = hit || (m_flag && !(wr && a == 3'd5 && wd[7]));
    for (int c = 0; c < 5; c++) n_frc[c] = wr && (a == 3'd4) && wd[7-c];
    n_cmp = m_cmp;
    if (wr && a == 3'd0) n_cmp[15:8] = wd;
    if (wr && a == 3'd1) n_cmp[7:0]  = wd;
    n_sel = (wr && a == 3'd2) ? wd[7:3] : m_sel;
    n_lvl = (wr && a == 3'd3) ? wd[7:3] : m_lvl;
    @(posedge clk);
    m_pins = n_pins; m_flag = n_flag; m_frc = n_frc;
    m_cmp = n_cmp; m_sel = n_sel; m_lvl = n_lvl;
    @(negedge clk);
    check({tag, " pins"},  {11'b0, pins_o},  {11'b0, m_pins});
    check({tag, " flag"},  {15'b0, irq_o},   {15'b0, m_flag});
    check({tag, " pulse"}, {11'b0, force_o}, {11'b0, m_frc});
  endtask

  task automatic wr(input string tag, input logic [2:0] a, input logic [7:0] d);
    cyc(tag, 1'b1, a, d, 16'hFFFF, 1'b0, 1'b0);
  endtask

  task automatic rd(input string tag, input logic [2:0] a);
    cyc(tag, 1'b0, a, 8'h00, 16'hFFFF, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c11));
    m_cmp = '0; m_sel = '0; m_lvl = '0; m_pins = '0; m_frc = '0; m_flag = 1'b0;
    rst_n = 1'b0; wr_en_i = 1'b0; addr_i = '0; wdata_i = '0; cnt_i = '0; cnt_adv_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 pins at reset", {11'b0, pins_o}, 16'h0);
    check("R1 flag at reset", {15'b0, irq_o}, 16'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 6; a++) rd("R1 reset readback", 3'(a));

    // R2: unimplemented bits, strobe reads zero
    wr("R2 sel write", 3'd2, 8'hFF);  rd("R2 sel bits", 3'd2);
    wr("R2 lvl write", 3'd3, 8'hAF);  rd("R2 lvl bits", 3'd3);
    rd("R2 strobe reads zero", 3'd4);

    // R3 / R5
    wr("R3 cmp hi", 3'd0, 8'h12); wr("R3 cmp lo", 3'd1, 8'h34);
    wr("R3 sel", 3'd2, 8'hA0);    wr("R3 lvl", 3'd3, 8'hFF);
    cyc("R5 equal without advance", 1'b0, 3'd0, 8'h00, 16'h1234, 1'b0, 1'b0);
    cyc("R3 match", 1'b0, 3'd0, 8'h00, 16'h1234, 1'b1, 1'b0);
    rd("R8 flag read", 3'd5);

    // R8 clear rules
    wr("R8 write zero keeps flag", 3'd5, 8'h00);
    wr("R8 write one clears", 3'd5, 8'h80);

    // R4: one selected pin changes, rest hold
    wr("R4 sel", 3'd2, 8'h08); wr("R4 lvl", 3'd3, 8'h08);
    cyc("R4 match", 1'b0, 3'd0, 8'h00, 16'h1234, 1'b1, 1'b0);
    wr("R8 clear", 3'd5, 8'h80);

    // R6 / R7 forced action and pulses
    wr("R6 sel", 3'd2, 8'hF8); wr("R6 lvl", 3'd3, 8'h50);
    wr("R6 force ch1", 3'd4, 8'h80);
    wr("R7 zero strobe", 3'd4, 8'h00);
    wr("R7 other channels", 3'd4, 8'h78);
    cyc("R7 idle after pulse", 1'b0, 3'd0, 8'h00, 16'h0000, 1'b0, 1'b0);

    // R8 set beats clear
    cyc("R8 match with clear", 1'b1, 3'd5, 8'h80, 16'h1234, 1'b1, 1'b0);

    // R10 write in the same cycle as a match uses old values
    wr("R10 lvl", 3'd3, 8'h00);
    cyc("R10 lvl write during match", 1'b1, 3'd3, 8'hF8, 16'h1234, 1'b1, 1'b0);
    cyc("R10 cmp write during match", 1'b1, 3'd1, 8'h00, 16'h1234, 1'b1, 1'b0);
    cyc("R6 force with match", 1'b1, 3'd4, 8'h80, 16'h1200, 1'b1, 1'b0);

    // R9 idle hold
    for (int k = 0; k < 4; k++) cyc("R9 idle", 1'b0, 3'd2, 8'h00, 16'h0001, 1'b1, 1'b1);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] cv;
      logic [2:0]  ra;
      cv = ($urandom % 2) ? m_cmp : 16'($urandom);
      ra = 3'($urandom % 7);
      cyc("R3/R4/R6/R8/R9 random", 1'($urandom % 3 == 0), ra, 8'($urandom),
          cv, 1'($urandom % 2), 1'b1);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule